// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 16-bit successive-approximation converter. It watches an asynchronous convert command. When that command falls, it starts a conversion, raises a busy flag and opens a gated conversion clock. It then walks a trial code from the most significant bit down to the least significant bit. The trial code feeds an external DAC. A single comparator answer comes back each cycle and decides the bit under test.

During a conversion the bit under test is held at 0 while every lower bit sits at 1. When that bit is decided, the next lower bit drops to 0. The decided bit takes the comparator answer. After the last decision the busy flag drops. The code on the output is then the finished result, and it holds until the next conversion. The gated clock gives one pulse per step, 17 pulses per conversion, and is low at all other times.

Top module: `sar_sequencer`

## Requirements
- R1: While reset (active low, synchronous) is asserted and right after it, busy is 0, the conversion clock is low and the code output is all ones.
- R2: The convert command passes through a two-flop synchronizer, and only its falling edge starts a conversion. Suppose the command is low at clock edge E and high at the edge before. Then busy rises at edge E+2. A rising edge of the command starts nothing.
- R3: On the edge that starts a conversion, the code becomes MSB = 0 with all 15 lower bits = 1.
- R4: On each of the next 16 edges, the bit being decided (bit 15 first, bit 0 last) takes the comparator input (1 keeps the bit set, 0 leaves it cleared). On the same edge the next lower bit is cleared, and all other bits stay unchanged.
- R5: Busy stays high for exactly 16 clock cycles. It falls on the edge that decides bit 0, and the code then equals the value decided bit by bit.
- R6: The conversion clock gives exactly 17 rising edges per conversion, one on each step edge. It is low whenever no conversion is running.
- R7: A command falling edge that is detected while busy is high is ignored. This includes one detected on the edge that decides bit 0: the sequence neither restarts nor changes.
- R8: While idle, the code output holds its value and the comparator input has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_cmd | input | 1 | Asynchronous convert command; its falling edge starts a conversion |
| cmp_in | input | 1 | Comparator answer for the bit under test (1 = keep set) |
| busy | output | 1 | High while a conversion is in progress |
| conv_clk | output | 1 | Gated conversion clock, 17 pulses per conversion |
| code | output | 16 | Trial code to the DAC; the result once busy is low |

## Verification
Two functions can meet in the same cycle: the final bit-0 decision, and the detection of a new command falling edge. The bench provokes this by lowering the command exactly three edges before the last decision edge, so the synchronized edge lands on that decision cycle. The reference model must show the decision taken, busy dropping and no restart, and the conversion clock count must stay at 17. A second command edge placed one cycle later must then be accepted as a normal new conversion.

// File: rtl/sar_seq_pkg.sv
// Package: shared helpers for the successive-approximation sequencer.
// Assumes: widths are at least 2.
package sar_seq_pkg;

    // Width of a counter that indexes the bits of a code of width w.
    function automatic int step_width(input int w);
        return (w > 2) ? $clog2(w) : 1;
    endfunction

endpackage

// File: rtl/sar_start_sync.sv
// Module: sar_start_sync
// Brings the asynchronous convert command into the clock domain through a
// chain of SYNC_STAGES flops. Flags one cycle when the synchronized level
// goes from high to low.
// Assumes: the command stays in each state for longer than the sync depth.
module sar_start_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_async,
    output logic fall_evt
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // Synchronizer chain plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], cmd_async};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    // Falling edge of the synchronized command.
    assign fall_evt = prev_q & ~sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/sar_step_ctrl.sv
// Module: sar_step_ctrl
// Owns the busy flag and the step counter. Accepts a start only when idle.
// Drives the gated conversion clock through a low-phase enable latch flop,
// so that each step edge, including the load edge, makes one clock pulse.
// Assumes: start_evt is a single-cycle pulse.
module sar_step_ctrl #(
    parameter int WIDTH  = 16,
    parameter int STEP_W = sar_seq_pkg::step_width(WIDTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    output logic              load,
    output logic              busy,
    output logic [STEP_W-1:0] step,
    output logic              conv_clk
);

    localparam logic [STEP_W-1:0] LAST = STEP_W'(WIDTH - 1);

    logic              busy_q;
    logic [STEP_W-1:0] step_q;
    logic              clk_en_q;
    logic              go;

    assign load = start_evt & ~busy_q;
    assign go   = load | busy_q;

    // Busy flag and step counter: load, then one decision per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            step_q <= '0;
        end else if (load) begin
            busy_q <= 1'b1;
            step_q <= '0;
        end else if (busy_q) begin
            step_q <= step_q + 1'b1;
            if (step_q == LAST) busy_q <= 1'b0;
        end
    end

    // Clock enable captured in the low phase, so the gated clock cannot glitch.
    always_ff @(negedge clk) begin
        if (!rst_n) clk_en_q <= 1'b0;
        else        clk_en_q <= go;
    end

    assign conv_clk = clk & clk_en_q;
    assign busy     = busy_q;
    assign step     = step_q;

    // R5: busy drops only after the last decision step.
    assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> $past(step_q) == LAST);

    // R7: a start seen mid-conversion leaves the sequence running on course.
    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start_evt && step_q != LAST) |=> (busy_q && step_q == $past(step_q) + 1'b1));

endmodule

// File: rtl/sar_trial_reg.sv
// Module: sar_trial_reg
// Per-bit trial register. On load, the MSB is cleared and the rest are set.
// On each advance, the bit under decision takes the comparator answer and
// the next lower bit is cleared.
// Assumes: step counts 0..WIDTH-1 while adv is high.
module sar_trial_reg #(
    parameter int WIDTH  = 16,
    parameter int STEP_W = sar_seq_pkg::step_width(WIDTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic [STEP_W-1:0] step,
    input  logic              cmp_in,
    output logic [WIDTH-1:0]  code
);

    logic [WIDTH-1:0] code_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        localparam int DEC_STEP = WIDTH - 1 - i;   // step that decides bit i
        localparam int CLR_STEP = WIDTH - 2 - i;   // step that clears bit i
        // One trial bit: preset, decide or clear, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 code_q[i] <= 1'b1;
            else if (load)                              code_q[i] <= (i != WIDTH - 1);
            else if (adv && int'(step) == DEC_STEP)     code_q[i] <= cmp_in;
            else if (adv && int'(step) == CLR_STEP)     code_q[i] <= 1'b0;
        end
    end

    assign code = code_q;

    // R3: load presents MSB cleared, all lower bits set.
    assert_load_pattern_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> code_q == {1'b0, {(WIDTH-1){1'b1}}});

    // R4: a step touches at most the decided bit and the next lower bit.
    assert_step_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> $countones(code_q ^ $past(code_q)) <= 2);

    // R8: idle code is frozen.
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !load) |=> $stable(code_q));

endmodule

// File: rtl/sar_sequencer.sv
// Module: sar_sequencer (top)
// Digital sequencer of a successive-approximation converter: synchronizes
// the convert command, runs one MSB-first bit search per falling edge and
// exposes the gated conversion clock and busy flag.
// Assumes: the comparator answer is valid one cycle after the code changes.
module sar_sequencer #(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_cmd,
    input  logic             cmp_in,
    output logic             busy,
    output logic             conv_clk,
    output logic [WIDTH-1:0] code
);

    localparam int STEP_W = sar_seq_pkg::step_width(WIDTH);

    logic              start_evt;
    logic              load;
    logic [STEP_W-1:0] step;

    sar_start_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_async (conv_cmd),
        .fall_evt  (start_evt)
    );

    sar_step_ctrl #(.WIDTH(WIDTH), .STEP_W(STEP_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_evt (start_evt),
        .load      (load),
        .busy      (busy),
        .step      (step),
        .conv_clk  (conv_clk)
    );

    sar_trial_reg #(.WIDTH(WIDTH), .STEP_W(STEP_W)) u_trial (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .adv    (busy),
        .step   (step),
        .cmp_in (cmp_in),
        .code   (code)
    );

    // R2: busy only rises after a synchronized falling edge.
    assert_start_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_evt));

endmodule

// File: tb/sar_sequencer_test.sv
`timescale 1ns/1ps
module sar_sequencer_test;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         conv_cmd = 1'b0;
    logic         cmp_in = 1'b0;
    logic         busy;
    logic         conv_clk;
    logic [W-1:0] code;

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;

    sar_sequencer #(.WIDTH(W), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .conv_cmd(conv_cmd), .cmp_in(cmp_in),
        .busy(busy), .conv_clk(conv_clk), .code(code)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference model.
    bit           m_pipe[$];      // command samples, oldest first
    bit           m_busy = 0;
    int           m_step = 0;
    logic [W-1:0] m_code = '1;
    string        m_tag = "R1";
    logic [W-1:0] target = '0;
    bit           idle_noise = 0;
    int           pulses = 0;
    int           busy_cycles = 0;

    always @(posedge clk) begin
        bit evt;
        if (!rst_n) begin
            m_pipe = '{0, 0, 0};
            m_busy = 0; m_step = 0; m_code = '1; m_tag = "R1";
        end else begin
            evt = m_pipe[0] && !m_pipe[1];   // prev high, synced now low
            if (evt && !m_busy) begin
                m_busy = 1; m_step = 0;
                m_code = '1; m_code[W-1] = 1'b0;
                m_tag = "R3";
            end else if (m_busy) begin
                m_code[W-1-m_step] = cmp_in;
                if (m_step < W-1) begin
                    m_code[W-2-m_step] = 1'b0;
                    m_tag = evt ? "R7" : "R4";
                end else begin
                    m_busy = 0;
                    m_tag = evt ? "R7" : "R5";
                end
                m_step++;
            end else begin
                m_tag = "R8";
            end
            void'(m_pipe.pop_front());
            m_pipe.push_back(conv_cmd);
        end
    end

    always @(posedge conv_clk) pulses++;

    // Compare every cycle in the low phase, then drive the next inputs.
    always @(negedge clk) begin
        vectors++;
        if (busy !== m_busy || code !== m_code) begin
            errors++;
            $display("FAIL %s: busy=%0b code=%h expected busy=%0b code=%h",
                     m_tag, busy, code, m_busy, m_code);
        end
        if (busy) busy_cycles++;
        if (m_busy) cmp_in <= target[W-1-m_step];
        else        cmp_in <= idle_noise;
    end

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse_cmd();
        @(negedge clk) conv_cmd = 1'b1;
        repeat (3) @(negedge clk);
        conv_cmd = 1'b0;
    endtask

    task automatic convert(input logic [W-1:0] t);
        target = t; pulses = 0; busy_cycles = 0;
        pulse_cmd();
        repeat (4) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        check("R4 result", int'(code), int'(t));
        check("R6 pulses", pulses, 17);
        check("R5 busy cycles", busy_cycles, 16);
    endtask

    task automatic check_idle_clk();
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1;
            check("R6 idle clock low", int'(conv_clk), 0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 code", int'(code), 16'hFFFF);
        rst_n = 1'b1;
        check_idle_clk();

        // R2: a rising edge alone starts nothing.
        @(negedge clk) conv_cmd = 1'b1;
        repeat (6) @(negedge clk);
        check("R2 rise only", int'(busy), 0);
        conv_cmd = 1'b0;           // this fall starts a conversion
        target = 16'h3A5C; pulses = 0; busy_cycles = 0;
        @(negedge clk); @(negedge clk);
        check("R2 not yet", int'(busy), 0);
        @(negedge clk);
        check("R2 busy after third edge", int'(busy), 1);
        check("R3 load pattern", int'(code), 16'h7FFF);
        while (busy) @(negedge clk);
        check("R5 result", int'(code), 16'h3A5C);
        check_idle_clk();

        convert(16'h0000);
        convert(16'hFFFF);
        convert(16'h8001);
        for (int n = 0; n < 4; n++) convert(W'($urandom));

        // R8: comparator toggling while idle has no effect.
        for (int k = 0; k < 6; k++) begin
            @(negedge clk) idle_noise = ~idle_noise;
        end
        repeat (2) @(negedge clk);
        check("R8 idle hold", int'(code), int'(target));

        // R7: command falls mid-conversion.
        target = 16'hC3A1; pulses = 0;
        pulse_cmd();
        repeat (6) @(negedge clk);
        conv_cmd = 1'b1; repeat (3) @(negedge clk); conv_cmd = 1'b0;
        while (busy) @(negedge clk);
        repeat (6) @(negedge clk);
        check("R7 mid restart ignored", int'(code), 16'hC3A1);
        check("R7 pulses", pulses, 17);

        // R7: synced edge lands on the bit-0 decision edge.
        target = 16'h5E17; pulses = 0;
        pulse_cmd();
        wait (m_busy);
        conv_cmd = 1'b1;
        while (!(m_busy && m_step == W-3)) @(negedge clk);
        conv_cmd = 1'b0;
        repeat (6) @(negedge clk);
        check("R7 coincident busy", int'(busy), 0);
        check("R7 coincident code", int'(code), 16'h5E17);
        check("R7 coincident pulses", pulses, 17);

        // A later edge is accepted normally.
        convert(16'h2B6D);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule